// File: doc/BRIEF.md
# Four-Condition Interrupting GPIO Controller

This block is a bank of general-purpose pins behind a small word-addressed register port. Software sets which pins listen (input mask) and which pins drive (output mask), writes the levels to drive, and reads back the synchronised pin levels. Every pin input passes through a two-stage synchroniser before anything looks at it.

Each pin can raise an interrupt on four independent conditions: a 0-to-1 transition, a 1-to-0 transition, a steady high level and a steady low level. Each condition has an enable mask and a sticky pending mask. Pending bits are cleared by writing ones to them. A level condition keeps setting its pending bit for as long as the level persists, so a clear only holds once the level has gone away. Each pin has its own interrupt line: the OR of its enabled and pending conditions.

The register port is a plain control interface: a request is accepted in the cycle it is presented, with no back-pressure. Read data comes back one cycle later.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register, `pin_out`, `pin_oe`, `irq` and `bus_rdata` are zero.
- R2: `pin_oe` equals the output-enable register, and `pin_out` equals the output-value register ANDed with the output-enable register.
- R3: The input-value register (byte offset 0x00) reads as the pin level after a two-flop synchroniser, ANDed with the input-enable register (offset 0x04).
- R4: A read request (`bus_valid`=1, `bus_write`=0) returns its data on `bus_rdata` in the following cycle. In every cycle that follows a non-read, `bus_rdata` is zero.
- R5: Rise pending bit i (offset 0x14) is set when the synchronised level of pin i goes from 0 to 1 while input enable i and rise enable i (offset 0x10) are set.
- R6: Fall pending bit i (offset 0x1C) is set when the synchronised level of pin i goes from 1 to 0 while input enable i and fall enable i (offset 0x18) are set.
- R7: High pending (offset 0x24, enable 0x20) and low pending (offset 0x2C, enable 0x28) are set on every cycle in which the synchronised pin is at that level with the condition and the input enabled. A clear therefore holds only once the level has changed.
- R8: A pending bit never becomes set while its condition's enable bit is clear.
- R9: Writing a pending register clears exactly the bits written as 1 and leaves the bits written as 0 unchanged. If a hardware set falls in the same cycle as a clear, the bit stays set.
- R10: `irq[i]` is high exactly when, for some condition, both the enable bit and the pending bit of pin i are set.
- R11: After disabling an edge condition, writing 1 to its pending bit and re-enabling it, the pending bit stays clear until a new edge occurs.
- R12: Registers are 32-bit words at byte offsets 0x00 input value (read-only), 0x04 input enable, 0x08 output enable, 0x0C output value, 0x10 to 0x2C the enable/pending pairs listed above. Unmapped offsets read as zero. Accesses with nonzero address bits [1:0] are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Levels driven on the pins |
| pin_oe | output | 32 | Per-pin output drive enable |
| irq | output | 32 | One interrupt line per pin |

## Verification
The bench builds the block with its default parameters: 32 pins, a 6-bit byte address and two synchroniser stages. With these values all twelve registers and the unmapped space above them can be addressed. The 32 pins let the high and low halves of the masks carry different patterns, and the stimulus can count the three-cycle path from a pin change to a pending bit exactly. A behavioural model compares the read data, the pin outputs and the interrupt lines on every clock. This covers the collision of a software clear with a level condition that is still active.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_COND = 4;

  // condition index; enable register sits at word 4+2c, pending at 5+2c
  typedef enum int {
    C_RISE = 0,
    C_FALL = 1,
    C_HIGH = 2,
    C_LOW  = 3
  } cond_e;

  typedef enum int {
    W_IN_VAL   = 0,
    W_IN_EN    = 1,
    W_OUT_EN   = 2,
    W_OUT_VAL  = 3,
    W_COND_BASE = 4
  } word_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [WIDTH-1:0]                  level,
  input  logic [WIDTH-1:0]                  listen,
  output logic [NUM_COND-1:0][WIDTH-1:0]    hit
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;

  always_comb begin
    hit[C_RISE] =  level & ~prev_q & listen;
    hit[C_FALL] = ~level &  prev_q & listen;
    hit[C_HIGH] =  level & listen;
    hit[C_LOW]  = ~level & listen;
  end
endmodule

// File: rtl/gpio_cond_bank.sv
module gpio_cond_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             pnd_we,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hit,
  output logic [WIDTH-1:0] en_q,
  output logic [WIDTH-1:0] pnd_q
);
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] set_vec;

  assign clr_mask = pnd_we ? wdata : '0;
  assign set_vec  = hit & en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      pnd_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      // hardware set applied after the clear so it wins a collision
      pnd_q <= (pnd_q & ~clr_mask) | set_vec;
    end

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnd_q & ~$past(pnd_q) & ~$past(en_q)) == '0)); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnd_q & $past(clr_mask & ~set_vec)) == '0)); // R9
  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pnd_q & $past(set_vec)) == $past(set_vec))); // R9
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             aligned, wr_ok, rd_ok;
  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] ien_q, oen_q, oval_q;
  logic [NPINS-1:0] rd_val;
  logic [NUM_COND-1:0][NPINS-1:0] hit, en_q, pnd_q;
  logic [NUM_COND-1:0] en_we, pnd_we;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_ok    = bus_valid &  bus_write & aligned;
  assign rd_ok    = bus_valid & ~bus_write & aligned;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(lvl_sync)
  );

  gpio_detect #(.WIDTH(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .level(lvl_sync), .listen(ien_q), .hit(hit)
  );

  for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
    localparam int EN_W  = W_COND_BASE + 2 * c;
    localparam int PND_W = W_COND_BASE + 2 * c + 1;
    assign en_we[c]  = wr_ok && (word_idx == IDX_W'(EN_W));
    assign pnd_we[c] = wr_ok && (word_idx == IDX_W'(PND_W));
    gpio_cond_bank #(.WIDTH(NPINS)) u_bank (
      .clk(clk), .rst_n(rst_n), .en_we(en_we[c]), .pnd_we(pnd_we[c]),
      .wdata(bus_wdata), .hit(hit[c]), .en_q(en_q[c]), .pnd_q(pnd_q[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien_q  <= '0;
      oen_q  <= '0;
      oval_q <= '0;
    end else if (wr_ok) begin
      if (word_idx == IDX_W'(W_IN_EN))   ien_q  <= bus_wdata;
      if (word_idx == IDX_W'(W_OUT_EN))  oen_q  <= bus_wdata;
      if (word_idx == IDX_W'(W_OUT_VAL)) oval_q <= bus_wdata;
    end

  always_comb begin
    rd_val = '0;
    if (word_idx == IDX_W'(W_IN_VAL))  rd_val = lvl_sync & ien_q;
    if (word_idx == IDX_W'(W_IN_EN))   rd_val = ien_q;
    if (word_idx == IDX_W'(W_OUT_EN))  rd_val = oen_q;
    if (word_idx == IDX_W'(W_OUT_VAL)) rd_val = oval_q;
    for (int c = 0; c < NUM_COND; c++) begin
      if (word_idx == IDX_W'(W_COND_BASE + 2 * c))     rd_val = en_q[c];
      if (word_idx == IDX_W'(W_COND_BASE + 2 * c + 1)) rd_val = pnd_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ok) bus_rdata <= rd_val;
    else            bus_rdata <= '0;

  always_comb begin
    irq = '0;
    for (int c = 0; c < NUM_COND; c++) irq = irq | (en_q[c] & pnd_q[c]);
  end

  assign pin_oe  = oen_q;
  assign pin_out = oval_q & oen_q;

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(bus_valid && !bus_write)) |-> (bus_rdata == '0)); // R4
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference, condition order: rise, fall, high, low
  logic [31:0] m_s1 = '0, m_s2 = '0, m_prv = '0;
  logic [31:0] m_ien = '0, m_oen = '0, m_oval = '0, m_rdata = '0;
  logic [31:0] m_en [4] = '{default: '0};
  logic [31:0] m_pnd[4] = '{default: '0};
  logic [31:0] m_hit[4];

  function automatic logic [31:0] model_read(int widx);
    if (widx == 0) return m_s2 & m_ien;
    if (widx == 1) return m_ien;
    if (widx == 2) return m_oen;
    if (widx == 3) return m_oval;
    if (widx >= 4 && widx <= 11)
      return (widx % 2 == 0) ? m_en[(widx - 4) / 2] : m_pnd[(widx - 4) / 2];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prv = 0; m_ien = 0; m_oen = 0; m_oval = 0; m_rdata = 0;
      for (int c = 0; c < 4; c++) begin m_en[c] = 0; m_pnd[c] = 0; end
    end else begin
      bit ok, wr, rd;
      int widx;
      ok = (bus_addr % 4) == 0;
      widx = bus_addr / 4;
      wr = bus_valid && bus_write && ok;
      rd = bus_valid && !bus_write && ok;
      m_hit[0] = m_s2 & ~m_prv & m_ien;
      m_hit[1] = ~m_s2 & m_prv & m_ien;
      m_hit[2] = m_s2 & m_ien;
      m_hit[3] = ~m_s2 & m_ien;
      m_rdata = rd ? model_read(widx) : 32'h0;
      for (int c = 0; c < 4; c++) begin
        logic [31:0] clr;
        clr = (wr && widx == 5 + 2 * c) ? bus_wdata : 32'h0;
        m_pnd[c] = (m_pnd[c] & ~clr) | (m_hit[c] & m_en[c]);
        if (wr && widx == 4 + 2 * c) m_en[c] = bus_wdata;
      end
      if (wr && widx == 1) m_ien = bus_wdata;
      if (wr && widx == 2) m_oen = bus_wdata;
      if (wr && widx == 3) m_oval = bus_wdata;
      m_prv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] m_irq;
      m_irq = 0;
      for (int c = 0; c < 4; c++) m_irq |= m_en[c] & m_pnd[c];
      chk("R4 rdata vs model", bus_rdata, m_rdata);
      chk("R2 pin_oe vs model", pin_oe, m_oen);
      chk("R2 pin_out vs model", pin_out, m_oval & m_oen);
      chk("R10 irq vs model", irq, m_irq);
    end
  end

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic pins(logic [31:0] v, int settle);
    @(negedge clk);
    pin_in = v;
    repeat (settle) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chk("R1 pin_out after reset", pin_out, 0);
    chk("R1 rdata after reset", bus_rdata, 0);
    bus_rd(6'h04, v); chk("R1 input enable reset", v, 0);
    bus_rd(6'h24, v); chk("R1 high pending reset", v, 0);

    bus_wr(6'h0C, 32'hA5A5_0F0F);
    bus_wr(6'h08, 32'hFFFF_0000);
    @(negedge clk);
    chk("R2 pin_out gated", pin_out, 32'hA5A5_0000);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    bus_rd(6'h0C, v); chk("R12 output value readback", v, 32'hA5A5_0F0F);

    pins(32'h1234_5678, 0);
    bus_wr(6'h04, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    bus_rd(6'h00, v); chk("R3 input value masked", v, 32'h0000_5678);

    bus_wr(6'h04, 32'hFFFF_FFFF);
    pins(32'h0, 4);
    bus_wr(6'h10, 32'h0000_0008);
    pins(32'h0000_0008, 4);
    bus_rd(6'h14, v); chk("R5 rise pending", v, 32'h8);
    chk("R10 irq from rise", irq, 32'h8);
    bus_wr(6'h14, 32'h0);
    bus_rd(6'h14, v); chk("R9 write zero keeps pending", v, 32'h8);
    bus_wr(6'h14, 32'h8);
    bus_rd(6'h14, v); chk("R9 write one clears", v, 32'h0);
    chk("R10 irq drops", irq, 32'h0);

    bus_wr(6'h18, 32'h0000_0010);
    pins(32'h0000_0018, 4);
    bus_rd(6'h1C, v); chk("R6 no fall on rising pin", v, 32'h0);
    bus_rd(6'h14, v); chk("R8 rise disabled on pin4", v, 32'h0);
    pins(32'h0000_0008, 4);
    bus_rd(6'h1C, v); chk("R6 fall pending", v, 32'h10);
    chk("R10 irq from fall", irq, 32'h10);

    bus_wr(6'h18, 32'h0);
    bus_wr(6'h1C, 32'h10);
    bus_wr(6'h18, 32'h10);
    repeat (6) @(negedge clk);
    bus_rd(6'h1C, v); chk("R11 no re-fire after clear", v, 32'h0);
    chk("R11 irq quiet", irq, 32'h0);

    bus_wr(6'h20, 32'h0000_0100);
    repeat (3) @(negedge clk);
    bus_rd(6'h24, v); chk("R7 high not set while low", v, 32'h0);
    pins(32'h0000_0108, 4);
    bus_rd(6'h24, v); chk("R7 high pending", v, 32'h100);
    bus_wr(6'h24, 32'h100);
    bus_rd(6'h24, v); chk("R9 hardware set wins clear", v, 32'h100);
    pins(32'h0000_0008, 4);
    bus_wr(6'h24, 32'h100);
    bus_rd(6'h24, v); chk("R7 clear sticks after level gone", v, 32'h0);

    bus_wr(6'h28, 32'h0000_0001);
    repeat (2) @(negedge clk);
    bus_rd(6'h2C, v); chk("R7 low pending", v, 32'h1);
    chk("R10 irq from low", irq, 32'h1);
    bus_wr(6'h28, 32'h0);
    bus_wr(6'h2C, 32'h1);
    bus_rd(6'h2C, v); chk("R8 low disabled stays clear", v, 32'h0);

    bus_rd(6'h30, v); chk("R12 unmapped reads zero", v, 32'h0);
    bus_rd(6'h05, v); chk("R12 misaligned read zero", v, 32'h0);
    bus_wr(6'h0D, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R12 misaligned write ignored", pin_out, 32'hA5A5_0000);
    repeat (4) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule